// File: doc/BRIEF.md
# PLL Retune Sequencer

This block moves a clock synthesiser from its present divider setting (reference divider M, feedback divider N, post divider PL) to a new one without letting the output glitch or overshoot. When only N changes and the loop is already running, it asks an external ramp engine to glide N smoothly and touches no register. Otherwise it takes the long path. It glides N down to the lowest legal VCO point, halves the output frequency with a temporary divide-by-2, and moves the output onto the bypass source. It then powers the loop up if needed, disables it, loads the new dividers at the minimum-VCO N and re-enables it. After waiting for lock it switches the output back to the VCO, restores divide-by-1 and glides N up to the target.

The sequencer reaches the synthesiser's control registers through a simple request/acknowledge register master, one access at a time. A lock input reports loop lock and a ramp handshake starts N glides. If anything fails during a pass that uses glides, the whole sequence is repeated once with glides turned off and the final N written directly. An error pulse is raised only when that second pass also fails; every other outcome ends in a done pulse.

Top module: `pll_reprog_seq`

## Requirements
- R1: When the loop is enabled (config bit 0 = 1) and the requested M and PL equal those in the coefficient register, the block performs no register write. It issues one glide to the new N, or no glide at all when N is also unchanged, and then pulses done.
- R2: When the loop is enabled and M or PL differs, and glides are allowed, the block first glides to the minimum-VCO N of the old M. Only then does it write any register.
- R3: The minimum-VCO N is ceil(M · MIN_VCO_KHZ / REF_KHZ), saturated to 255.
- R4: The long path first writes the output-divider register with its 6-bit field at bits 13:8 set to 2, other bits kept. It then writes the select register with bit 0 (VCO select) cleared.
- R5: If the power-down bit (config bit 1) is set, it is cleared by a config write followed by a config read. Next, enable (config bit 0) is cleared by a config write before the coefficients are written.
- R6: The coefficient word holds M at bits 7:0, N at bits 15:8 and PL at bits 21:16. Its N is the minimum-VCO N of the new M in a gliding pass and the target N otherwise. The next write sets enable.
- R7: If lock-detect-off (config bit 4) is set, it is cleared by a config write. The block then waits for pll_lock for at most LOCK_US · CLK_MHZ cycles, and a timeout is a failure.
- R8: After lock, the select register is written with bit 0 set. If the divider field then reads non-zero, the divider register is written twice with the field set to 0 (divide-by-1) and read back. Otherwise it is not written.
- R9: A gliding pass ends with a glide to the target N before done.
- R10: A failure (ramp fail or lock timeout) in a gliding pass restarts the sequence from the register reads with glides disabled. A failure in that pass pulses err instead of done. done and err are one-cycle pulses, never together.
- R11: reg_req holds its address, direction and data stable until reg_ack. ramp_req holds its target until ramp_done or ramp_fail. The two requests are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a retune with new_m/new_n/new_pl (sampled when idle) |
| new_m | input | 8 | Requested reference divider |
| new_n | input | 8 | Requested feedback divider |
| new_pl | input | 6 | Requested post divider code |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 2 | 0 config, 1 coefficients, 2 output select, 3 output divider |
| reg_wdata | output | 32 | Write data |
| reg_ack | input | 1 | Access complete; read data valid |
| reg_rdata | input | 32 | Read data |
| ramp_req | output | 1 | Request an N glide |
| ramp_target | output | 8 | N to glide to |
| ramp_done | input | 1 | Glide finished |
| ramp_fail | input | 1 | Glide failed |
| pll_lock | input | 1 | Loop locked |
| done | output | 1 | Retune finished successfully (pulse) |
| err | output | 1 | Retune failed in both passes (pulse) |

## Verification
The bench models the register file, the ramp engine and a lock that follows enable and power-down. It logs every write and glide target and compares the logs with sequences worked out from the requirements. It drives a cold start with power-down and lock-detect-off set, a pure glide, an unchanged request, an M change, and a glide failure forcing the fallback. It also covers a divider field that is already 1 after lock, a double lock timeout, and a sweep of M for the minimum-VCO N. Typical faults these expose: a design that writes the coefficients while still enabled or with the target N would show the wrong write order or N field. One that skips the early glide would show a missing ramp target. One that errors on the first failure, or loops forever, would show err on the fallback case or no second coefficient write on the timeout case.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int M_W  = 8;
    localparam int N_W  = 8;
    localparam int PL_W = 6;
    localparam int DW   = 32;

    // register selects seen by the register master
    localparam logic [1:0] RA_CFG   = 2'd0;
    localparam logic [1:0] RA_COEFF = 2'd1;
    localparam logic [1:0] RA_SEL   = 2'd2;
    localparam logic [1:0] RA_OUT   = 2'd3;

    // bit positions decoded by the synthesiser
    localparam int CFG_EN     = 0;
    localparam int CFG_PWRDN  = 1;
    localparam int CFG_LDOFF  = 4;
    localparam int SEL_VCO    = 0;
    localparam int DIV_LSB    = 8;
    localparam int DIV_W      = 6;
    localparam logic [DIV_W-1:0] DIV_HALF = 6'd2;
    localparam logic [DIV_W-1:0] DIV_ONE  = 6'd0;

    typedef struct packed {
        logic [PL_W-1:0] pl;
        logic [N_W-1:0]  n;
        logic [M_W-1:0]  m;
    } coef_t;

    typedef enum logic [4:0] {
        S_IDLE, S_RD_COEFF, S_RD_CFG, S_DECIDE, S_RAMP_DOWN,
        S_RD_OUT, S_WR_HALF, S_RD_SEL, S_WR_BYP, S_WR_PWRUP,
        S_RB_PWRUP, S_WR_DIS, S_WR_COEFF, S_WR_EN, S_WR_LDON,
        S_WAIT_LOCK, S_WR_VCO, S_RD_OUT2, S_WR_ONE_A, S_WR_ONE_B,
        S_RB_OUT, S_RAMP_UP
    } seq_state_e;

    function automatic logic [DW-1:0] coef_word(input coef_t c);
        return {{(DW-PL_W-N_W-M_W){1'b0}}, c.pl, c.n, c.m};
    endfunction

    function automatic coef_t word_coef(input logic [DW-1:0] w);
        coef_t c;
        c.m  = w[M_W-1:0];
        c.n  = w[M_W+N_W-1:M_W];
        c.pl = w[M_W+N_W+PL_W-1:M_W+N_W];
        return c;
    endfunction

    function automatic logic [DW-1:0] set_div(input logic [DW-1:0] w,
                                              input logic [DIV_W-1:0] f);
        logic [DW-1:0] r;
        r = w;
        r[DIV_LSB +: DIV_W] = f;
        return r;
    endfunction

    function automatic logic [N_W-1:0] min_vco_n(input logic [M_W-1:0] m,
                                                 input int unsigned vco_khz,
                                                 input int unsigned ref_khz);
        logic [39:0] num;
        logic [39:0] q;
        num = 40'(m) * 40'(vco_khz) + 40'(ref_khz - 1);
        q   = num / 40'(ref_khz);
        return (q > 40'((1 << N_W) - 1)) ? {N_W{1'b1}} : q[N_W-1:0];
    endfunction

endpackage

// File: rtl/pll_nlo_calc.sv
module pll_nlo_calc
    import pll_seq_pkg::*;
#(
    parameter int unsigned REF_KHZ     = 38400,
    parameter int unsigned MIN_VCO_KHZ = 1000000
) (
    input  logic [M_W-1:0] m,
    output logic [N_W-1:0] n_lo
);
    always_comb n_lo = min_vco_n(m, MIN_VCO_KHZ, REF_KHZ);
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
    parameter int LIMIT = 15000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (!expired) cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == W'(LIMIT));
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int unsigned REF_KHZ     = 38400,
    parameter int unsigned MIN_VCO_KHZ = 1000000,
    parameter int unsigned CLK_MHZ     = 50,
    parameter int unsigned LOCK_US     = 300
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [7:0]  new_m,
    input  logic [7:0]  new_n,
    input  logic [5:0]  new_pl,
    output logic        reg_req,
    output logic        reg_we,
    output logic [1:0]  reg_addr,
    output logic [31:0] reg_wdata,
    input  logic        reg_ack,
    input  logic [31:0] reg_rdata,
    output logic        ramp_req,
    output logic [7:0]  ramp_target,
    input  logic        ramp_done,
    input  logic        ramp_fail,
    input  logic        pll_lock,
    output logic        done,
    output logic        err
);
    localparam int LOCK_CYCLES = int'(LOCK_US * CLK_MHZ);

    seq_state_e     st, nxt;
    coef_t          tgt, old;
    logic [DW-1:0]  cfg_q, sel_q, out_q;
    logic           glide_q;
    logic [N_W-1:0] nlo_old, nlo_new;
    logic           lock_expired;
    logic           fin_ok, fin_bad, fail_evt, retry;

    pll_nlo_calc #(.REF_KHZ(REF_KHZ), .MIN_VCO_KHZ(MIN_VCO_KHZ)) u_nlo_old (
        .m(old.m), .n_lo(nlo_old));
    pll_nlo_calc #(.REF_KHZ(REF_KHZ), .MIN_VCO_KHZ(MIN_VCO_KHZ)) u_nlo_new (
        .m(tgt.m), .n_lo(nlo_new));

    pll_lock_timer #(.LIMIT(LOCK_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .run(st == S_WAIT_LOCK), .expired(lock_expired));

    always_comb begin
        coef_t c;
        nxt         = st;
        reg_req     = 1'b0;
        reg_we      = 1'b0;
        reg_addr    = RA_CFG;
        reg_wdata   = '0;
        ramp_req    = 1'b0;
        ramp_target = tgt.n;
        fin_ok      = 1'b0;
        fail_evt    = 1'b0;
        c           = tgt;
        c.n         = glide_q ? nlo_new : tgt.n;
        case (st)
            S_IDLE:      if (start) nxt = S_RD_COEFF;
            S_RD_COEFF: begin
                reg_req = 1'b1; reg_addr = RA_COEFF;
                if (reg_ack) nxt = S_RD_CFG;
            end
            S_RD_CFG: begin
                reg_req = 1'b1; reg_addr = RA_CFG;
                if (reg_ack) nxt = S_DECIDE;
            end
            S_DECIDE: begin
                if (glide_q && cfg_q[CFG_EN]) begin
                    if (tgt.m == old.m && tgt.pl == old.pl) begin
                        if (tgt.n == old.n) begin
                            fin_ok = 1'b1;
                            nxt    = S_IDLE;
                        end else begin
                            nxt = S_RAMP_UP;
                        end
                    end else begin
                        nxt = S_RAMP_DOWN;
                    end
                end else begin
                    nxt = S_RD_OUT;
                end
            end
            S_RAMP_DOWN: begin
                ramp_req = 1'b1; ramp_target = nlo_old;
                if (ramp_fail)      fail_evt = 1'b1;
                else if (ramp_done) nxt = S_RD_OUT;
            end
            S_RD_OUT: begin
                reg_req = 1'b1; reg_addr = RA_OUT;
                if (reg_ack) nxt = S_WR_HALF;
            end
            S_WR_HALF: begin
                reg_req = 1'b1; reg_we = 1'b1; reg_addr = RA_OUT;
                reg_wdata = set_div(out_q, DIV_HALF);
                if (reg_ack) nxt = S_RD_SEL;
            end
            S_RD_SEL: begin
                reg_req = 1'b1; reg_addr = RA_SEL;
                if (reg_ack) nxt = S_WR_BYP;
            end
            S_WR_BYP: begin
                reg_req = 1'b1; reg_we = 1'b1; reg_addr = RA_SEL;
                reg_wdata = sel_q;
                reg_wdata[SEL_VCO] = 1'b0;
                if (reg_ack) nxt = cfg_q[CFG_PWRDN] ? S_WR_PWRUP : S_WR_DIS;
            end
            S_WR_PWRUP: begin
                reg_req = 1'b1; reg_we = 1'b1; reg_addr = RA_CFG;
                reg_wdata = cfg_q;
                reg_wdata[CFG_PWRDN] = 1'b0;
                if (reg_ack) nxt = S_RB_PWRUP;
            end
            S_RB_PWRUP: begin
                reg_req = 1'b1; reg_addr = RA_CFG;
                if (reg_ack) nxt = S_WR_DIS;
            end
            S_WR_DIS: begin
                reg_req = 1'b1; reg_we = 1'b1; reg_addr = RA_CFG;
                reg_wdata = cfg_q;
                reg_wdata[CFG_EN] = 1'b0;
                if (reg_ack) nxt = S_WR_COEFF;
            end
            S_WR_COEFF: begin
                reg_req = 1'b1; reg_we = 1'b1; reg_addr = RA_COEFF;
                reg_wdata = coef_word(c);
                if (reg_ack) nxt = S_WR_EN;
            end
            S_WR_EN: begin
                reg_req = 1'b1; reg_we = 1'b1; reg_addr = RA_CFG;
                reg_wdata = cfg_q;
                reg_wdata[CFG_EN] = 1'b1;
                if (reg_ack) nxt = cfg_q[CFG_LDOFF] ? S_WR_LDON : S_WAIT_LOCK;
            end
            S_WR_LDON: begin
                reg_req = 1'b1; reg_we = 1'b1; reg_addr = RA_CFG;
                reg_wdata = cfg_q;
                reg_wdata[CFG_LDOFF] = 1'b0;
                if (reg_ack) nxt = S_WAIT_LOCK;
            end
            S_WAIT_LOCK: begin
                if (pll_lock)          nxt = S_WR_VCO;
                else if (lock_expired) fail_evt = 1'b1;
            end
            S_WR_VCO: begin
                reg_req = 1'b1; reg_we = 1'b1; reg_addr = RA_SEL;
                reg_wdata = sel_q;
                reg_wdata[SEL_VCO] = 1'b1;
                if (reg_ack) nxt = S_RD_OUT2;
            end
            S_RD_OUT2: begin
                reg_req = 1'b1; reg_addr = RA_OUT;
                if (reg_ack) begin
                    if (reg_rdata[DIV_LSB +: DIV_W] != DIV_ONE) nxt = S_WR_ONE_A;
                    else if (glide_q)                           nxt = S_RAMP_UP;
                    else begin fin_ok = 1'b1; nxt = S_IDLE; end
                end
            end
            S_WR_ONE_A: begin
                reg_req = 1'b1; reg_we = 1'b1; reg_addr = RA_OUT;
                reg_wdata = set_div(out_q, DIV_ONE);
                if (reg_ack) nxt = S_WR_ONE_B;
            end
            S_WR_ONE_B: begin
                reg_req = 1'b1; reg_we = 1'b1; reg_addr = RA_OUT;
                reg_wdata = set_div(out_q, DIV_ONE);
                if (reg_ack) nxt = S_RB_OUT;
            end
            S_RB_OUT: begin
                reg_req = 1'b1; reg_addr = RA_OUT;
                if (reg_ack) begin
                    if (glide_q) nxt = S_RAMP_UP;
                    else begin fin_ok = 1'b1; nxt = S_IDLE; end
                end
            end
            S_RAMP_UP: begin
                ramp_req = 1'b1; ramp_target = tgt.n;
                if (ramp_fail)      fail_evt = 1'b1;
                else if (ramp_done) begin fin_ok = 1'b1; nxt = S_IDLE; end
            end
            default: nxt = S_IDLE;
        endcase
        retry   = fail_evt && glide_q;
        fin_bad = fail_evt && !glide_q;
        if (fail_evt) nxt = glide_q ? S_RD_COEFF : S_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            tgt     <= '0;
            old     <= '0;
            cfg_q   <= '0;
            sel_q   <= '0;
            out_q   <= '0;
            glide_q <= 1'b1;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            st   <= nxt;
            done <= fin_ok;
            err  <= fin_bad;
            if (st == S_IDLE && start) begin
                tgt.m   <= new_m;
                tgt.n   <= new_n;
                tgt.pl  <= new_pl;
                glide_q <= 1'b1;
            end
            if (retry) glide_q <= 1'b0;
            if (reg_req && reg_ack) begin
                case (reg_addr)
                    RA_CFG:   cfg_q <= reg_we ? reg_wdata : reg_rdata;
                    RA_SEL:   sel_q <= reg_we ? reg_wdata : reg_rdata;
                    RA_OUT:   out_q <= reg_we ? reg_wdata : reg_rdata;
                    default:  if (!reg_we) old <= word_coef(reg_rdata);
                endcase
            end
        end
    end
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_req,
    input logic        reg_we,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        reg_ack,
    input logic        ramp_req,
    input logic [7:0]  ramp_target,
    input logic        ramp_done,
    input logic        ramp_fail,
    input logic        pll_lock,
    input logic        done,
    input logic        err
);
    // lock observed since the last coefficient load
    logic lock_seen;
    always_ff @(posedge clk) begin
        if (rst) lock_seen <= 1'b0;
        else if (reg_req && reg_we && reg_addr == 2'd1) lock_seen <= 1'b0;
        else if (pll_lock) lock_seen <= 1'b1;
    end

    assert_reg_hold_R11: assert property (@(posedge clk) disable iff (rst)
        reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we)
                                && $stable(reg_wdata));

    assert_ramp_hold_R11: assert property (@(posedge clk) disable iff (rst)
        ramp_req && !ramp_done && !ramp_fail |=> ramp_req && $stable(ramp_target));

    assert_one_master_R11: assert property (@(posedge clk) disable iff (rst)
        !(reg_req && ramp_req));

    assert_end_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_err_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    assert_vco_after_lock_R8: assert property (@(posedge clk) disable iff (rst)
        reg_req && reg_we && reg_addr == 2'd2 && reg_wdata[0] |-> lock_seen);
endmodule

bind pll_reprog_seq pll_reprog_seq_chk u_chk (
    .clk(clk), .rst(rst), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
    .ramp_req(ramp_req), .ramp_target(ramp_target), .ramp_done(ramp_done),
    .ramp_fail(ramp_fail), .pll_lock(pll_lock), .done(done), .err(err));

// File: tb/sim_pll_reprog_seq.sv
module sim_pll_reprog_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  new_m = '0, new_n = '0;
    logic [5:0]  new_pl = '0;
    logic        reg_req, reg_we, reg_ack = 1'b0;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata = '0;
    logic        ramp_req, ramp_done = 1'b0, ramp_fail = 1'b0;
    logic [7:0]  ramp_target;
    logic        pll_lock;
    logic        done, err;

    always #10 clk = ~clk;

    pll_reprog_seq u0 (.*);

    // synthesiser register model
    logic [31:0] r_cfg = 32'h12, r_coeff = 32'h0, r_sel = 32'h0, r_out = 32'h3C;
    logic [1:0]  wa [0:511];
    logic [31:0] wd [0:511];
    int          wn = 0;
    int          rt [0:127];
    int          rn = 0;
    int          rcnt = 0;
    int          lcnt = 0;
    bit          fail_next = 0, lock_block = 0, clobber = 0;
    int          cyc = 0;
    int          nchk = 0, nfail = 0;

    assign pll_lock = (lcnt >= 20);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (r_cfg[0] && !r_cfg[1] && !lock_block) lcnt <= (lcnt < 20) ? lcnt + 1 : lcnt;
        else lcnt <= 0;
        if (reg_req && !reg_ack) begin
            reg_ack <= 1'b1;
            if (reg_we) begin
                wa[wn] <= reg_addr; wd[wn] <= reg_wdata; wn <= wn + 1;
                case (reg_addr)
                    2'd0: begin
                        r_cfg <= reg_wdata;
                        if (clobber && reg_wdata[0]) r_out[13:8] <= 6'd0;
                        if (!reg_wdata[0]) lcnt <= 0;
                    end
                    2'd1: r_coeff <= reg_wdata;
                    2'd2: r_sel <= reg_wdata;
                    default: r_out <= reg_wdata;
                endcase
            end else begin
                case (reg_addr)
                    2'd0: reg_rdata <= r_cfg;
                    2'd1: reg_rdata <= r_coeff;
                    2'd2: reg_rdata <= r_sel;
                    default: reg_rdata <= r_out;
                endcase
            end
        end else reg_ack <= 1'b0;
        ramp_done <= 1'b0;
        ramp_fail <= 1'b0;
        if (ramp_req && !ramp_done && !ramp_fail) begin
            if (rcnt == 4) begin
                rcnt <= 0;
                rt[rn] <= int'(ramp_target); rn <= rn + 1;
                if (fail_next) begin ramp_fail <= 1'b1; fail_next <= 0; end
                else begin ramp_done <= 1'b1; r_coeff[15:8] <= ramp_target; end
            end else rcnt <= rcnt + 1;
        end
        if (cyc == 199000) begin
            nfail = nfail + 1; nchk = nchk + 1;
            $display("FAIL watchdog: run did not finish (actual hung, expected end)");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    function automatic int nlo(input int m);
        int q;
        q = (m * 1000000 + 38399) / 38400;
        return (q > 255) ? 255 : q;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    int wb, rb, t0;
    bit got_done, got_err;

    task automatic run(input int m, input int n, input int pl);
        wb = wn; rb = rn;
        @(negedge clk);
        new_m = 8'(m); new_n = 8'(n); new_pl = 6'(pl); start = 1'b1;
        t0 = cyc;
        @(negedge clk);
        start = 1'b0;
        got_done = 0; got_err = 0;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (done || err) begin got_done = done; got_err = err; break; end
        end
    endtask

    task automatic expw(input int k, input int a, input longint d, input string tag);
        check(wb + k < wn && wa[wb + k] == 2'(a) && wd[wb + k] == 32'(d), tag,
              (wb + k < wn) ? {wa[wb + k], wd[wb + k]} : 64'hDEAD, {2'(a), 32'(d)});
    endtask

    function automatic longint cw(input int m, input int n, input int pl);
        return longint'((pl << 16) | (n << 8) | m);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check(!done && !err && !reg_req && !ramp_req, "reset R10", {done, err, reg_req, ramp_req}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // cold start: disabled, power-down and lock-detect-off set
        run(3, 200, 2);
        check(got_done && !got_err, "cold done R10", {got_done, got_err}, 2);
        check(wn - wb == 10, "cold write count R8", wn - wb, 10);
        expw(0, 3, 32'h23C, "half divider R4");
        expw(1, 2, 32'h0, "bypass select R4");
        expw(2, 0, 32'h10, "power-up R5");
        expw(3, 0, 32'h10, "disable before coeff R5");
        expw(4, 1, cw(3, nlo(3), 2), "coeff at min-VCO N R6");
        expw(5, 0, 32'h11, "enable R6");
        expw(6, 0, 32'h01, "lock-detect on R7");
        expw(7, 2, 32'h1, "vco select R8");
        expw(8, 3, 32'h3C, "div1 first R8");
        expw(9, 3, 32'h3C, "div1 second R8");
        check(rn - rb == 1 && rt[rb] == 200, "glide up R9", rt[rb], 200);

        // pure glide
        run(3, 180, 2);
        check(got_done && wn == wb, "pure glide no writes R1", wn - wb, 0);
        check(rn - rb == 1 && rt[rb] == 180, "pure glide target R1", rt[rb], 180);
        check(r_coeff == 32'(cw(3, 180, 2)), "pure glide coeff R1", r_coeff, cw(3, 180, 2));

        // unchanged request
        run(3, 180, 2);
        check(got_done && wn == wb && rn == rb, "no-op R1", (wn - wb) + (rn - rb), 0);

        // M change while running
        run(5, 210, 2);
        check(got_done && rn - rb == 2, "m change glides R2", rn - rb, 2);
        check(rt[rb] == nlo(3), "glide down to old min N R2", rt[rb], nlo(3));
        check(rt[rb + 1] == 210, "glide up R9", rt[rb + 1], 210);
        check(wn - wb == 8, "m change writes R5", wn - wb, 8);
        expw(2, 0, 32'h0, "disable R5");
        expw(3, 1, cw(5, nlo(5), 2), "coeff R6");
        expw(4, 0, 32'h1, "enable R6");

        // glide failure forces fallback pass
        fail_next = 1;
        run(4, 190, 3);
        check(got_done && !got_err, "fallback done R10", {got_done, got_err}, 2);
        check(rn - rb == 1 && rt[rb] == nlo(5), "fallback glides R10", rn - rb, 1);
        expw(3, 1, cw(4, 190, 3), "fallback direct N R6");
        check(wn - wb == 8, "fallback writes R10", wn - wb, 8);

        // divider already 1 after lock: no divider rewrite
        clobber = 1;
        run(6, 220, 3);
        clobber = 0;
        check(got_done && wn - wb == 6, "div already 1 R8", wn - wb, 6);
        expw(5, 2, 32'h1, "last write is select R8");
        check(rn - rb == 2 && rt[rb + 1] == 220, "div1 glide up R9", rt[rb + 1], 220);

        // lock never arrives in either pass
        lock_block = 1;
        run(7, 150, 2);
        lock_block = 0;
        check(got_err && !got_done, "double timeout err R10", {got_err, got_done}, 1);
        check(cyc - t0 >= 30000, "timeout length R7", cyc - t0, 30000);
        check(rn - rb == 1 && rt[rb] == nlo(6), "timeout glides R7", rn - rb, 1);
        begin
            int k; k = 0;
            for (int i = wb; i < wn; i++) if (wa[i] == 2'd1) begin
                if (k == 0) check(wd[i] == 32'(cw(7, nlo(7), 2)), "first coeff R7", wd[i], cw(7, nlo(7), 2));
                else        check(wd[i] == 32'(cw(7, 150, 2)), "retry coeff R10", wd[i], cw(7, 150, 2));
                k++;
            end
            check(k == 2, "two coeff loads R10", k, 2);
        end

        // sweep of M for the minimum-VCO N
        for (int m = 1; m <= 9; m++) begin
            run(m, 240, 1);
            check(got_done, "sweep done R3", got_done, 1);
            for (int i = wb; i < wn; i++)
                if (wa[i] == 2'd1)
                    check(wd[i][15:8] == 8'(nlo(m)), "min-VCO N R3", wd[i][15:8], nlo(m));
            check(rt[rn - 1] == 240 && r_coeff == 32'(cw(m, 240, 1)), "sweep final R9",
                  r_coeff, cw(m, 240, 1));
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule